// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

This block counts down a preset value and raises an interrupt when the count runs out. An 8-bit binary down-counter takes its value from a preset input. It decrements once per tick of one of four strobes, which a 2-bit select chooses. The strobes come from outside the block: two from a prescaler (a fast 4096 Hz rate and a slow 64 Hz rate) and two from the calendar (a once-per-second update and a once-per-minute update). Each strobe is a single-cycle pulse in the `clk` domain.

When the count reaches zero, a sticky timer flag sets and the active-low request `irq_n` may assert. There are two interrupt modes:
- **One-shot mode:** the count stops at zero and the request stays low until software clears the flag.
- **Repeating mode:** the counter reloads the preset and keeps counting. The request is a fixed pulse lasting `PULSE_TICKS` fast-strobe periods, while the flag still holds until it is cleared.

A preset of zero never produces an event. The `irq_n` output stands for an open-drain pin: 1 means released (high impedance) and 0 means pulled low.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `itvl_timer`

## Requirements
- R1: After reset, `tmr_flag` is 0 and `irq_n` is 1.
- R2: While `run_en` is 0, the counter follows `preset` and ticks have no effect. Setting `run_en` to 1 starts the count from the preset. Dropping `run_en` and raising it again restarts from the preset; there is no pause.
- R3: With `preset` = N (N ≥ 1) and the timer enabled, the flag stays 0 after N−1 selected ticks. It is 1 two clock cycles after the N-th tick is sampled.
- R4: `src_sel` picks the counting strobe: 00 selects `tick_4k`, 01 selects `tick_64`, 10 selects `upd_sec`, and 11 selects `upd_min`. Strobes that are not selected do not count.
- R5: With `repeat_mode` = 0 (one-shot), there is no reload. After expiry, further ticks produce no new event.
- R6: In one-shot mode with `irq_en` = 1, `irq_n` stays 0 while the flag is 1. A one-cycle `flag_clr` pulse clears the flag and releases `irq_n`.
- R7: With `irq_en` = 0, `irq_n` stays 1 even though the flag still sets.
- R8: A preset of 0 never sets the flag, whatever the number of ticks.
- R9: With `repeat_mode` = 1, the counter reloads the preset at expiry and fires again every N ticks. `irq_n` is 0 for exactly `PULSE_TICKS` (default 16) `tick_4k` strobes after each expiry. The flag stays 1 until it is cleared.
- R10: The flag can only be set by an expiry. It stays 1 until `flag_clr` is pulsed, and an expiry in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_4k | input | 1 | 4096 Hz strobe, one cycle wide |
| tick_64 | input | 1 | 64 Hz strobe, one cycle wide |
| upd_sec | input | 1 | Once-per-second calendar update strobe |
| upd_min | input | 1 | Once-per-minute calendar update strobe |
| run_en | input | 1 | Timer enable; 0 holds the preset |
| src_sel | input | 2 | Tick source select (see R4) |
| repeat_mode | input | 1 | 1 = repeating pulse with reload, 0 = one-shot level |
| irq_en | input | 1 | Request enable |
| preset | input | 8 | Reload value |
| flag_clr | input | 1 | One-cycle pulse that clears the timer flag |
| tmr_flag | output | 1 | Sticky expiry flag |
| irq_n | output | 1 | Active-low request; 1 = released |

## Verification
The bench targets these corner cases:
- **Enable restart:** it disables the timer halfway through a count and enables it again. A design that paused instead of reloading would fire two ticks early.
- **Zero preset:** it runs a zero preset through many ticks. A counter that wrapped from 0 to 255 would eventually fire.
- **Pulse width:** in repeating mode, it counts the fast strobes across the pulse. Off-by-one pulse logic shows up at the 15th or 16th strobe.
- **Reload:** after the flag is cleared, it checks that a second period fires without the preset being rewritten. Unselected strobes are applied throughout, so a design that counted the wrong source fires too early.

// File: rtl/itvl_pkg.sv
package itvl_pkg;
  typedef enum logic [1:0] {
    SRC_FAST = 2'b00,
    SRC_SLOW = 2'b01,
    SRC_SEC  = 2'b10,
    SRC_MIN  = 2'b11
  } src_e;
  localparam int NUM_SRC = 4;
endpackage

// File: rtl/itvl_tick_sel.sv
module itvl_tick_sel
  import itvl_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic [NSRC-1:0]         strobes,
  input  logic [$clog2(NSRC)-1:0] sel,
  output logic                    tick
);
  logic [NSRC-1:0] hit;
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = strobes[g] && (sel == g[$clog2(NSRC)-1:0]);
  end
  assign tick = |hit;
endmodule

// File: rtl/itvl_down_cnt.sv
module itvl_down_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             repeat_mode,
  input  logic [CNT_W-1:0] preset,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      zero_evt <= 1'b0;
    end else begin
      zero_evt <= 1'b0;
      if (!run_en) begin
        cnt <= preset;
      end else if (tick && cnt != '0) begin
        if (cnt == ONE) begin
          zero_evt <= 1'b1;
          cnt      <= repeat_mode ? preset : '0;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  AST_EVT_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && cnt == ONE) |=> zero_evt);  // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !zero_evt);  // R2
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && cnt == '0 && !repeat_mode) |=> !zero_evt);  // R5
endmodule

// File: rtl/itvl_irq_ctl.sv
module itvl_irq_ctl #(
  parameter int PULSE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic tick_fast,
  input  logic repeat_mode,
  input  logic irq_en,
  input  logic flag_clr,
  output logic tmr_flag,
  output logic irq_n
);
  localparam int PW_W = $clog2(PULSE_TICKS + 1);
  localparam logic [PW_W-1:0] PW_LOAD = PW_W'(PULSE_TICKS);
  logic [PW_W-1:0] pw_cnt;
  logic            pw_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_flag <= 1'b0;
      pw_cnt   <= '0;
    end else begin
      if (zero_evt)      tmr_flag <= 1'b1;
      else if (flag_clr) tmr_flag <= 1'b0;
      if (zero_evt)                     pw_cnt <= PW_LOAD;
      else if (tick_fast && pw_cnt != '0) pw_cnt <= pw_cnt - PW_W'(1);
    end
  end

  assign pw_act = (pw_cnt != '0);
  assign irq_n  = !(irq_en && (repeat_mode ? pw_act : tmr_flag));

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> tmr_flag);  // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !flag_clr) |=> tmr_flag);  // R10
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> pw_act);  // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n);  // R7
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !repeat_mode && !flag_clr) |=> (!irq_n || !irq_en || repeat_mode));  // R6
endmodule

// File: rtl/itvl_timer.sv
module itvl_timer
  import itvl_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PULSE_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_4k,
  input  logic             tick_64,
  input  logic             upd_sec,
  input  logic             upd_min,
  input  logic             run_en,
  input  logic [1:0]       src_sel,
  input  logic             repeat_mode,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] preset,
  input  logic             flag_clr,
  output logic             tmr_flag,
  output logic             irq_n
);
  logic [NUM_SRC-1:0] strobes;
  logic               tick;
  logic               zero_evt;

  assign strobes = {upd_min, upd_sec, tick_64, tick_4k};

  itvl_tick_sel #(.NSRC(NUM_SRC)) u_sel (
    .strobes(strobes), .sel(src_sel), .tick(tick)
  );

  itvl_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
    .repeat_mode(repeat_mode), .preset(preset), .zero_evt(zero_evt)
  );

  itvl_irq_ctl #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
    .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .tick_fast(tick_4k),
    .repeat_mode(repeat_mode), .irq_en(irq_en), .flag_clr(flag_clr),
    .tmr_flag(tmr_flag), .irq_n(irq_n)
  );

  AST_ZERO_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && preset == '0) |=> !zero_evt);  // R8
endmodule

// File: tb/sim_itvl_timer.sv
module sim_itvl_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_4k = 0, tick_64 = 0, upd_sec = 0, upd_min = 0;
  logic run_en = 0, repeat_mode = 0, irq_en = 0, flag_clr = 0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] preset = 8'd0;
  logic tmr_flag, irq_n;

  always #2 clk = ~clk;

  itvl_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .tick_64(tick_64),
    .upd_sec(upd_sec), .upd_min(upd_min), .run_en(run_en), .src_sel(src_sel),
    .repeat_mode(repeat_mode), .irq_en(irq_en), .preset(preset),
    .flag_clr(flag_clr), .tmr_flag(tmr_flag), .irq_n(irq_n)
  );

  typedef struct {
    string req;
    bit    flag;
    bit    irqn;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (tmr_flag !== e.flag || irq_n !== e.irqn) begin
        n_bad++;
        $display("FAIL %s: flag/irq_n actual %b/%b expected %b/%b",
                 e.req, tmr_flag, irq_n, e.flag, e.irqn);
      end
    end
  end

  task automatic expect_out(string req, bit f, bit i);
    exp_t e;
    e.req = req; e.flag = f; e.irqn = i;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic strobe(int s, int n);
    for (int k = 0; k < n; k++) begin
      case (s)
        0: tick_4k = 1'b1;
        1: tick_64 = 1'b1;
        2: upd_sec = 1'b1;
        default: upd_min = 1'b1;
      endcase
      @(negedge clk);
      tick_4k = 0; tick_64 = 0; upd_sec = 0; upd_min = 0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic restart();
    run_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 reset", 0, 1);

    // R3: one-shot countdown, preset 3 on the fast strobe
    irq_en = 1; preset = 8'd3; src_sel = 2'b00;
    restart();
    strobe(0, 2);
    expect_out("R3 before Nth tick", 0, 1);
    strobe(0, 1);
    expect_out("R3 at Nth tick", 1, 0);
    // R5: no reload in one-shot; R6: level held
    strobe(0, 5);
    expect_out("R6 level held", 1, 0);
    clear_flag();
    expect_out("R6 cleared", 0, 1);
    strobe(0, 6);
    expect_out("R5 no refire", 0, 1);

    // R2: ticks ignored while disabled, restart from preset
    run_en = 0; preset = 8'd4;
    @(negedge clk);
    strobe(0, 10);
    expect_out("R2 disabled", 0, 1);
    run_en = 1; @(negedge clk);
    strobe(0, 2);
    restart();
    strobe(0, 3);
    expect_out("R2 restart no pause", 0, 1);
    strobe(0, 1);
    expect_out("R2 fires at preset", 1, 0);
    clear_flag();

    // R4: each select; unselected strobes ignored
    for (int s = 1; s < 4; s++) begin
      src_sel = s[1:0]; preset = 8'd2;
      restart();
      for (int o = 0; o < 4; o++) if (o != s) strobe(o, 3);
      expect_out($sformatf("R4 sel %0d others ignored", s), 0, 1);
      strobe(s, 2);
      expect_out($sformatf("R4 sel %0d counts", s), 1, 0);
      clear_flag();
    end

    // R7: masked request
    irq_en = 0; src_sel = 2'b01; preset = 8'd1;
    restart();
    strobe(1, 1);
    expect_out("R7 masked", 1, 1);
    clear_flag();
    irq_en = 1;

    // R8: zero preset
    preset = 8'd0; src_sel = 2'b00;
    restart();
    strobe(0, 300);
    expect_out("R8 zero preset", 0, 1);

    // R9: repeating mode on the seconds strobe
    repeat_mode = 1; preset = 8'd2; src_sel = 2'b10;
    restart();
    strobe(2, 2);
    expect_out("R9 pulse start", 1, 0);
    strobe(0, 15);
    expect_out("R9 pulse at 15", 1, 0);
    strobe(0, 1);
    expect_out("R9 pulse end flag held", 1, 1);
    clear_flag();
    strobe(2, 1);
    expect_out("R9 reload half", 0, 1);
    strobe(2, 1);
    expect_out("R9 reload refire", 1, 0);

    // R10: clear and expiry in the same cycle, expiry wins
    clear_flag();
    strobe(0, 16);
    strobe(2, 1);
    upd_sec = 1'b1;
    @(negedge clk);
    upd_sec = 1'b0;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
    expect_out("R10 set beats clear", 1, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule